// File: doc/BRIEF.md
# Periodic Timer Interrupt Rate Divider

This block turns a 64 Hz strobe into a periodic interrupt at one of three slower or equal rates. A single byte-wide control register holds the rate selection in its two low bits. Software writes the register to pick a rate, and it reads the same register to acknowledge a pending interrupt. No separate clear register exists.

Each strobe advances an internal tick counter unless the selection disables interrupts. When the advanced count passes the selection value, the interrupt line is raised and the counter restarts from zero. The line is a registered level. It stays high until the next read of the register. A write always restarts the count, so a new rate takes effect from a clean phase. The upper six bits of the register are stored and read back unchanged, and they have no effect on the rate. The 64 Hz strobe itself is an input: it is one clock cycle wide and averages 15.625 ms between pulses.

Top module: `rtc_irq_divider`

## Requirements
- R1: After reset the register reads 0x02 and `irq_o` is low.
- R2: With selection code 0 in bits [1:0], every strobe raises `irq_o` after the next clock edge.
- R3: With selection code 1, `irq_o` is raised on every second strobe counted from the last write.
- R4: With selection code 3, `irq_o` is raised on every fourth strobe counted from the last write.
- R5: With selection code 2, strobes never raise `irq_o` and do not advance the count.
- R6: A write stores all eight bits, and `rd_data_o` returns them unchanged until the next write. Only bits [1:0] affect the rate.
- R7: A write clears the count. A strobe that arrives in the same cycle as a write is discarded.
- R8: Once raised, `irq_o` stays high until a cycle with `rd_en_i` high. It is low after the edge that ends that cycle.
- R9: If a strobe raises the interrupt in the same cycle as a read, `irq_o` stays high.
- R10: Cycles without a strobe leave the count and `irq_o` unchanged, apart from a read clearing `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 64 Hz strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read; acknowledges the interrupt |
| rd_data_o | output | 8 | Current register contents |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Two pairs of events can land in the same cycle, and the bench drives both of them deliberately. In the first pair, a read acknowledge coincides with a strobe that expires the count. The bench judges this case by `irq_o` staying high after the edge. In the second pair, a write coincides with a strobe. The bench then counts further strobes and checks that the interrupt arrives only after a full period measured from the write, which shows that the coinciding strobe was dropped.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;
    localparam int REG_W  = 8;
    localparam int SEL_W  = 2;
    localparam logic [SEL_W-1:0] SEL_OFF = 2'd2;
    localparam logic [REG_W-1:0] REG_RST = 8'h02;

    typedef enum logic [SEL_W-1:0] {
        RATE_64  = 2'd0,
        RATE_32  = 2'd1,
        RATE_OFF = 2'd2,
        RATE_16  = 2'd3
    } rate_sel_e;
endpackage

// File: rtl/rtcdiv_modereg.sv
module rtcdiv_modereg #(
    parameter int REG_W = rtcdiv_pkg::REG_W,
    parameter int SEL_W = rtcdiv_pkg::SEL_W,
    parameter logic [REG_W-1:0] RST_VAL = rtcdiv_pkg::REG_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] value,
    output logic [SEL_W-1:0] sel
);
    typedef struct packed {
        logic [REG_W-1:0] mode;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mode = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.mode;
    assign sel   = st_q.mode[SEL_W-1:0];

    // R6: a write lands in full on the next cycle
    a_r6_wr_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> value == $past(wr_data));
    // R6: without a write the register holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value));
endmodule

// File: rtl/rtcdiv_counter.sv
module rtcdiv_counter #(
    parameter int SEL_W = rtcdiv_pkg::SEL_W,
    parameter logic [SEL_W-1:0] OFF_CODE = rtcdiv_pkg::SEL_OFF,
    localparam int CNT_W = SEL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(sel);

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        inc  = st_q.cnt + CNT_W'(1);
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick && (sel != OFF_CODE)) begin
            if (inc > limit) begin
                fire     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2/R3/R4: count never passes the selection value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= limit);
    // R7: a write leaves the count at zero
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.cnt == '0);
    // R5: a disabled selection freezes the count
    a_r5_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == OFF_CODE && !clear) |=> $stable(st_q.cnt));
    // R10: no strobe, no movement
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(st_q.cnt));
endmodule

// File: rtl/rtcdiv_irqflag.sv
module rtcdiv_irqflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.irq = 1'b1;
        end else if (ack) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    // R9: expiry beats acknowledge
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);
    // R8: acknowledge drops the line
    a_r8_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> !irq);
    // R8: level held otherwise
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !set) |=> $stable(irq));
endmodule

// File: rtl/rtc_irq_divider.sv
module rtc_irq_divider #(
    parameter int REG_W = rtcdiv_pkg::REG_W,
    parameter int SEL_W = rtcdiv_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o
);
    logic [SEL_W-1:0] sel;
    logic             fire;

    rtcdiv_modereg #(.REG_W(REG_W), .SEL_W(SEL_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .value   (rd_data_o),
        .sel     (sel)
    );

    rtcdiv_counter #(.SEL_W(SEL_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_i),
        .clear (wr_en_i),
        .sel   (sel),
        .fire  (fire)
    );

    rtcdiv_irqflag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fire),
        .ack   (rd_en_i),
        .irq   (irq_o)
    );

    // R5: with interrupts off, a low line stays low
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == rtcdiv_pkg::SEL_OFF && !wr_en_i && !irq_o) |=> !irq_o);
endmodule

// File: tb/rtc_irq_divider_bench.sv
module rtc_irq_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rtc_irq_divider u_rtc_irq_divider (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] wdata;
        logic       rd;
        logic       tick;
        logic       exp_irq;
        logic [7:0] exp_rd;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // 0  sel 0
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // 1  R2 fire
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00}, // 2  R8 held
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // 3  R8 ack
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // 4  R2
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00}, // 5  R9 tick+read
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // 6  ack
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00}, // 7  sel 1
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 8  R3 first
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // 9  R10 idle
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // 10 R3 second fires
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA1}, // 11 R6 readback
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 12 partial count
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00}, // 13 R7 clear
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 14 R7 restart
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // 15 R3
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA1}, // 16
        '{1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, 8'h00}, // 17 sel 3
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 18 R4
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 19 R4
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 20 R4
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // 21 R4 fourth fires
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h7F}, // 22 R6
        '{1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 8'h00}, // 23 sel 2
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 24 R5
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 25 R5
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 26 R5
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 27 R5
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFE}, // 28 R6 upper bits kept
        '{1'b1, 8'h03, 1'b0, 1'b1, 1'b0, 8'h00}, // 29 R7 write+tick
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 30
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 31
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 32 R7 dropped strobe
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // 33 R7 full period
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h03}  // 34
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [7:0] wd, input logic rd,
                        input logic tk, input logic exp_irq, input logic [7:0] exp_rd,
                        input string req);
        @(negedge clk);
        wr_en_i = wr; wr_data_i = wd; rd_en_i = rd; tick_i = tk;
        #0.5;
        if (rd) check(rd_data_o == exp_rd, req, rd_data_o, exp_rd);
        @(posedge clk);
        #1;
        wr_en_i = 1'b0; rd_en_i = 1'b0; tick_i = 1'b0;
        check(irq_o == exp_irq, req, irq_o, exp_irq);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check(rd_data_o == 8'h02, "R1 reset value", rd_data_o, 8'h02);
        check(irq_o == 1'b0, "R1 reset irq", irq_o, 0);

        // R5: interrupts off straight out of reset
        for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R5 reset off");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].wr, VECS[i].wdata, VECS[i].rd, VECS[i].tick,
                 VECS[i].exp_irq, VECS[i].exp_rd, $sformatf("R2-table vec %0d", i));
        end

        // R10: many idle cycles with a pending interrupt keep it high
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R10 setup");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, "R2 fire");
        for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, "R10 idle hold");

        // R1: reset mid-operation clears line and register
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(irq_o == 1'b0, "R1 async reset irq", irq_o, 0);
        check(rd_data_o == 8'h02, "R1 async reset value", rd_data_o, 8'h02);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R1 off after reset");

        finish_run();
    end
endmodule